// File: doc/BRIEF.md
# Command Queue Doorbell and Error Control

This block keeps the control state of one command queue. Software rings a doorbell by writing a number of 64-bit words, and the block adds that number to a pending word count. The instruction fetch logic consumes eight words each time it accepts an instruction. An addition that goes past the top of the counter is not lost without trace: it raises a status bit.

A five-bit status register collects miscellaneous events. These are a mailbox write, a doorbell overflow, an instruction read error, a result write error and an engine software error. Each event can be set by hardware pulses or by a software set-write, and is cleared by writing one. A matching enable register, with separate set and clear writes, masks the status bits onto one interrupt line.

The queue enable bit is cleared automatically when one of the three error causes is recorded, unless continue-on-error is set. The block also reports the queue as quiescent when it is disabled and nothing is in flight. Control writes that arrive while the queue is not quiescent can only clear the enable.

Top module: `cmdq_bell_ctrl`

## Requirements
- R1: After reset the pending count, status, interrupt enables, queue enable and continue-on-error are all zero, and the interrupt line is low.
- R2: A doorbell write adds its value to the pending count, visible the cycle after the write. The low three bits of the written value are ignored, so only multiples of 8 are added.
- R3: If an addition exceeds the largest count the counter can hold, status bit 1 (doorbell overflow) is set and the count keeps only its low bits.
- R4: A fetch accept lowers the count by 8 when the count is at least 8. It is ignored when the count is below 8. A doorbell write and a fetch accept in the same cycle are both applied.
- R5: Status bit encoding: bit0 mailbox write, bit1 doorbell overflow, bit2 instruction read error, bit3 result write error, bit4 engine software error. Hardware pulses set bits 0, 2, 3 and 4. A clear-write removes each bit written as one, and a set event in the same cycle wins over the clear.
- R6: A software set-write sets each status bit written as one, with the same effects as a hardware set.
- R7: The interrupt enable register uses the bit layout of the status register. A set-write turns on the bits written as one and a clear-write turns off the bits written as one. If both touch the same bit in one cycle, the set wins. The current enables are readable.
- R8: The interrupt line is high exactly when some status bit and its enable bit are both set.
- R9: With continue-on-error clear, any set event on status bit 1, 2 or 3, from hardware or from a software set-write, clears the queue enable in the next cycle. Set events on bits 0 and 4 leave it unchanged.
- R10: With continue-on-error set, set events on bits 1, 2 and 3 leave the queue enable unchanged.
- R11: The quiescent output is high only when the queue is disabled and the in-flight count is zero.
- R12: A control write while quiescent loads the queue enable and continue-on-error. While not quiescent, only a write of enable zero has an effect: it clears the enable, and continue-on-error is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bellWrEn | input | 1 | Doorbell write strobe |
| bellWrData | input | CNT_W | Words to add to the pending count |
| fetchTake | input | 1 | Fetch logic accepts one instruction (8 words) |
| stsSetEn | input | 1 | Software set-write to status |
| stsSetData | input | 5 | Status bits to set |
| stsClrEn | input | 1 | Write-one-to-clear write to status |
| stsClrData | input | 5 | Status bits to clear |
| enaSetEn | input | 1 | Set-write to interrupt enables |
| enaSetData | input | 5 | Enable bits to set |
| enaClrEn | input | 1 | Clear-write to interrupt enables |
| enaClrData | input | 5 | Enable bits to clear |
| ctlWrEn | input | 1 | Queue control write strobe |
| ctlWrEna | input | 1 | Written queue enable value |
| ctlWrContErr | input | 1 | Written continue-on-error value |
| mboxWr | input | 1 | Mailbox write pulse |
| fetchRdErr | input | 1 | Instruction read error pulse |
| resWrErr | input | 1 | Result write error pulse |
| engSwErr | input | 1 | Engine software error pulse |
| inflightCnt | input | INFL_W | Instructions currently in flight |
| pendCnt | output | CNT_W | Pending doorbell word count |
| stsOut | output | 5 | Status register value |
| enaOut | output | 5 | Interrupt enable register value |
| queueEna | output | 1 | Queue enabled |
| contErrOut | output | 1 | Continue-on-error setting |
| irqOut | output | 1 | Interrupt line |
| quiescent | output | 1 | Queue disabled and nothing in flight |

## Verification
The bench builds the block with an 8-bit counter instead of the default 20 bits. This brings the overflow boundary within a couple of doorbell writes of 248 and 16 words, so the wrap to the low bits and the overflow-driven queue disable are both reached in a few cycles. The in-flight width stays at its default of 8 bits. Driving it to a small nonzero value is enough to show that a disabled queue is still not quiescent and still refuses control writes.

// File: rtl/cmdq_bell_pkg.sv
package cmdq_bell_pkg;

  localparam int CAUSE_N = 5;

  // Status / enable bit positions (software decodes these)
  localparam int IDX_MAIL     = 0;
  localparam int IDX_BELLOVF  = 1;
  localparam int IDX_FETCHERR = 2;
  localparam int IDX_RESERR   = 3;
  localparam int IDX_ENGERR   = 4;

  // Causes that stop the queue unless continue-on-error is set
  localparam logic [CAUSE_N-1:0] STOP_MASK =
    (CAUSE_N'(1) << IDX_BELLOVF) | (CAUSE_N'(1) << IDX_FETCHERR) | (CAUSE_N'(1) << IDX_RESERR);

  typedef struct packed {
    logic doAdd;
    logic doTake;
  } bellStrobe_t;

endpackage

// File: rtl/cmdq_bell_count.sv
module cmdq_bell_count
  import cmdq_bell_pkg::*;
#(
  parameter int CNT_W      = 20,
  parameter int INST_WORDS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bellStrobe_t      strobe,
  input  logic [CNT_W-1:0] addVal,
  output logic [CNT_W-1:0] pendCnt,
  output logic             ovfHit
);

  localparam int ALIGN_W = $clog2(INST_WORDS);
  localparam int SUM_W   = CNT_W + 1;
  localparam logic [CNT_W-1:0] INST_STEP = CNT_W'(INST_WORDS);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] alignedAdd;
  logic             takeOk;
  logic [CNT_W-1:0] afterTake;
  logic [SUM_W-1:0] wideSum;

  generate
    if (ALIGN_W > 0) begin : g_mask
      assign alignedAdd = {addVal[CNT_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
    end else begin : g_nomask
      assign alignedAdd = addVal;
    end
  endgenerate

  always_comb begin
    takeOk    = strobe.doTake && (cntQ >= INST_STEP);
    afterTake = takeOk ? (cntQ - INST_STEP) : cntQ;
    wideSum   = {1'b0, afterTake} + (strobe.doAdd ? {1'b0, alignedAdd} : '0);
    ovfHit    = strobe.doAdd && wideSum[CNT_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cntQ <= '0;
    else        cntQ <= wideSum[CNT_W-1:0];
  end

  assign pendCnt = cntQ;

endmodule

// File: rtl/cmdq_bell_ctrl_fsm.sv
module cmdq_bell_ctrl_fsm
  import cmdq_bell_pkg::*;
#(
  parameter int INFL_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bellWrEn,
  input  logic               fetchTake,
  input  logic               ovfHit,
  input  logic               stsSetEn,
  input  logic [CAUSE_N-1:0] stsSetData,
  input  logic               stsClrEn,
  input  logic [CAUSE_N-1:0] stsClrData,
  input  logic               enaSetEn,
  input  logic [CAUSE_N-1:0] enaSetData,
  input  logic               enaClrEn,
  input  logic [CAUSE_N-1:0] enaClrData,
  input  logic               ctlWrEn,
  input  logic               ctlWrEna,
  input  logic               ctlWrContErr,
  input  logic               mboxWr,
  input  logic               fetchRdErr,
  input  logic               resWrErr,
  input  logic               engSwErr,
  input  logic [INFL_W-1:0]  inflightCnt,
  output bellStrobe_t        strobe,
  output logic [CAUSE_N-1:0] stsQ,
  output logic [CAUSE_N-1:0] enaQ,
  output logic               queueEnaQ,
  output logic               contErrQ,
  output logic               irq,
  output logic               quiet
);

  logic [CAUSE_N-1:0] hwSet;
  logic [CAUSE_N-1:0] setVec;
  logic [CAUSE_N-1:0] clrVec;
  logic [CAUSE_N-1:0] enaSetVec;
  logic [CAUSE_N-1:0] enaClrVec;
  logic               stopHit;

  always_comb begin
    hwSet               = '0;
    hwSet[IDX_MAIL]     = mboxWr;
    hwSet[IDX_BELLOVF]  = ovfHit;
    hwSet[IDX_FETCHERR] = fetchRdErr;
    hwSet[IDX_RESERR]   = resWrErr;
    hwSet[IDX_ENGERR]   = engSwErr;
    setVec    = hwSet | (stsSetEn ? stsSetData : '0);
    clrVec    = stsClrEn ? stsClrData : '0;
    enaSetVec = enaSetEn ? enaSetData : '0;
    enaClrVec = enaClrEn ? enaClrData : '0;
    stopHit   = (|(setVec & STOP_MASK)) && !contErrQ;
    strobe.doAdd  = bellWrEn;
    strobe.doTake = fetchTake;
  end

  // One flop per cause bit; set wins over clear in both registers.
  genvar b;
  generate
    for (b = 0; b < CAUSE_N; b++) begin : g_cause
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stsQ[b] <= 1'b0;
          enaQ[b] <= 1'b0;
        end else begin
          stsQ[b] <= setVec[b] | (stsQ[b] & ~clrVec[b]);
          enaQ[b] <= enaSetVec[b] | (enaQ[b] & ~enaClrVec[b]);
        end
      end
    end
  endgenerate

  assign quiet = !queueEnaQ && (inflightCnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      queueEnaQ <= 1'b0;
      contErrQ  <= 1'b0;
    end else begin
      if (ctlWrEn && quiet) contErrQ <= ctlWrContErr;
      if (stopHit)
        queueEnaQ <= 1'b0;
      else if (ctlWrEn)
        queueEnaQ <= quiet ? ctlWrEna : (queueEnaQ & ctlWrEna);
    end
  end

  assign irq = |(stsQ & enaQ);

endmodule

// File: rtl/cmdq_bell_ctrl.sv
module cmdq_bell_ctrl
  import cmdq_bell_pkg::*;
#(
  parameter int CNT_W      = 20,
  parameter int INFL_W     = 8,
  parameter int INST_WORDS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bellWrEn,
  input  logic [CNT_W-1:0]   bellWrData,
  input  logic               fetchTake,
  input  logic               stsSetEn,
  input  logic [4:0]         stsSetData,
  input  logic               stsClrEn,
  input  logic [4:0]         stsClrData,
  input  logic               enaSetEn,
  input  logic [4:0]         enaSetData,
  input  logic               enaClrEn,
  input  logic [4:0]         enaClrData,
  input  logic               ctlWrEn,
  input  logic               ctlWrEna,
  input  logic               ctlWrContErr,
  input  logic               mboxWr,
  input  logic               fetchRdErr,
  input  logic               resWrErr,
  input  logic               engSwErr,
  input  logic [INFL_W-1:0]  inflightCnt,
  output logic [CNT_W-1:0]   pendCnt,
  output logic [4:0]         stsOut,
  output logic [4:0]         enaOut,
  output logic               queueEna,
  output logic               contErrOut,
  output logic               irqOut,
  output logic               quiescent
);

  bellStrobe_t strobe;
  logic        ovfHit;

  cmdq_bell_ctrl_fsm #(.INFL_W(INFL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .bellWrEn(bellWrEn), .fetchTake(fetchTake), .ovfHit(ovfHit),
    .stsSetEn(stsSetEn), .stsSetData(stsSetData),
    .stsClrEn(stsClrEn), .stsClrData(stsClrData),
    .enaSetEn(enaSetEn), .enaSetData(enaSetData),
    .enaClrEn(enaClrEn), .enaClrData(enaClrData),
    .ctlWrEn(ctlWrEn), .ctlWrEna(ctlWrEna), .ctlWrContErr(ctlWrContErr),
    .mboxWr(mboxWr), .fetchRdErr(fetchRdErr), .resWrErr(resWrErr), .engSwErr(engSwErr),
    .inflightCnt(inflightCnt),
    .strobe(strobe), .stsQ(stsOut), .enaQ(enaOut),
    .queueEnaQ(queueEna), .contErrQ(contErrOut), .irq(irqOut), .quiet(quiescent)
  );

  cmdq_bell_count #(.CNT_W(CNT_W), .INST_WORDS(INST_WORDS)) u_count (
    .clk(clk), .rst_n(rst_n),
    .strobe(strobe), .addVal(bellWrData),
    .pendCnt(pendCnt), .ovfHit(ovfHit)
  );

endmodule

// File: rtl/cmdq_bell_ctrl_chk.sv
module cmdq_bell_ctrl_chk #(
  parameter int CNT_W      = 20,
  parameter int INFL_W     = 8,
  parameter int INST_WORDS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bellWrEn,
  input logic [CNT_W-1:0]  bellWrData,
  input logic              fetchTake,
  input logic              stsSetEn,
  input logic [4:0]        stsSetData,
  input logic              stsClrEn,
  input logic [4:0]        stsClrData,
  input logic              mboxWr,
  input logic              fetchRdErr,
  input logic              resWrErr,
  input logic              ctlWrEn,
  input logic [INFL_W-1:0] inflightCnt,
  input logic [CNT_W-1:0]  pendCnt,
  input logic [4:0]        stsOut,
  input logic [4:0]        enaOut,
  input logic              queueEna,
  input logic              contErrOut,
  input logic              irqOut,
  input logic              quiescent
);

  localparam int ALIGN_W = $clog2(INST_WORDS);
  localparam logic [CNT_W:0] TOP = {1'b0, {CNT_W{1'b1}}};
  localparam logic [CNT_W-1:0] STEP = CNT_W'(INST_WORDS);

  logic [CNT_W:0] addWide;
  assign addWide = {1'b0, pendCnt} + {1'b0, (bellWrData >> ALIGN_W) << ALIGN_W};

  // R3: an overflowing add without a same-cycle take raises the overflow bit
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bellWrEn && !fetchTake && addWide > TOP) |=> stsOut[1]);

  // R4: a lone take with enough words lowers the count by one instruction
  assert_take_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetchTake && !bellWrEn && pendCnt >= STEP) |=> pendCnt == $past(pendCnt) - STEP);

  // R4: a lone take below one instruction leaves the count alone
  assert_take_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetchTake && !bellWrEn && pendCnt < STEP) |=> $stable(pendCnt));

  // R9: hardware read/write errors stop the queue when not continuing on error
  assert_err_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((fetchRdErr || resWrErr) && !contErrOut) |=> !queueEna);

  // R5: clearing the mailbox bit with no set event leaves it clear
  assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stsClrEn && stsClrData[0] && !mboxWr && !(stsSetEn && stsSetData[0])) |=> !stsOut[0]);

  // R8: no enables means no interrupt
  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enaOut == 5'd0) |-> !irqOut);

  // R11: quiescent implies the queue is off and nothing is in flight
  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    quiescent |-> (!queueEna && inflightCnt == '0));

  // R12: a busy queue keeps its continue-on-error setting across control writes
  assert_ctl_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctlWrEn && !quiescent) |=> $stable(contErrOut));

endmodule

bind cmdq_bell_ctrl cmdq_bell_ctrl_chk #(
  .CNT_W(CNT_W), .INFL_W(INFL_W), .INST_WORDS(INST_WORDS)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .bellWrEn(bellWrEn), .bellWrData(bellWrData), .fetchTake(fetchTake),
  .stsSetEn(stsSetEn), .stsSetData(stsSetData),
  .stsClrEn(stsClrEn), .stsClrData(stsClrData),
  .mboxWr(mboxWr), .fetchRdErr(fetchRdErr), .resWrErr(resWrErr),
  .ctlWrEn(ctlWrEn), .inflightCnt(inflightCnt),
  .pendCnt(pendCnt), .stsOut(stsOut), .enaOut(enaOut),
  .queueEna(queueEna), .contErrOut(contErrOut), .irqOut(irqOut), .quiescent(quiescent)
);

// File: tb/cmdq_bell_ctrl_tb.sv
module cmdq_bell_ctrl_tb;

  localparam int BW = 8;
  localparam int NV = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bellWrEn = 0;
  logic [BW-1:0] bellWrData = '0;
  logic          fetchTake = 0;
  logic          stsSetEn = 0, stsClrEn = 0, enaSetEn = 0, enaClrEn = 0;
  logic [4:0]    stsSetData = '0, stsClrData = '0, enaSetData = '0, enaClrData = '0;
  logic          ctlWrEn = 0, ctlWrEna = 0, ctlWrContErr = 0;
  logic          mboxWr = 0, fetchRdErr = 0, resWrErr = 0, engSwErr = 0;
  logic [7:0]    inflightCnt = '0;
  logic [BW-1:0] pendCnt;
  logic [4:0]    stsOut, enaOut;
  logic          queueEna, contErrOut, irqOut, quiescent;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  cmdq_bell_ctrl #(.CNT_W(BW), .INFL_W(8), .INST_WORDS(8)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .bellWrEn(bellWrEn), .bellWrData(bellWrData), .fetchTake(fetchTake),
    .stsSetEn(stsSetEn), .stsSetData(stsSetData),
    .stsClrEn(stsClrEn), .stsClrData(stsClrData),
    .enaSetEn(enaSetEn), .enaSetData(enaSetData),
    .enaClrEn(enaClrEn), .enaClrData(enaClrData),
    .ctlWrEn(ctlWrEn), .ctlWrEna(ctlWrEna), .ctlWrContErr(ctlWrContErr),
    .mboxWr(mboxWr), .fetchRdErr(fetchRdErr), .resWrErr(resWrErr), .engSwErr(engSwErr),
    .inflightCnt(inflightCnt),
    .pendCnt(pendCnt), .stsOut(stsOut), .enaOut(enaOut),
    .queueEna(queueEna), .contErrOut(contErrOut), .irqOut(irqOut), .quiescent(quiescent)
  );

  // {add, value, take, expected count}
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 8'd16, 1'b0, 8'd16},
    {1'b1, 8'd13, 1'b0, 8'd24},
    {1'b0, 8'd0,  1'b1, 8'd16},
    {1'b1, 8'd8,  1'b1, 8'd16},
    {1'b0, 8'd0,  1'b1, 8'd8},
    {1'b0, 8'd0,  1'b1, 8'd0},
    {1'b0, 8'd0,  1'b1, 8'd0},
    {1'b1, 8'd4,  1'b0, 8'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    bellWrEn = 0; fetchTake = 0;
    stsSetEn = 0; stsClrEn = 0; enaSetEn = 0; enaClrEn = 0;
    ctlWrEn = 0; mboxWr = 0; fetchRdErr = 0; resWrErr = 0; engSwErr = 0;
  endtask

  task automatic ctlWrite(input logic ena, input logic ce);
    ctlWrEn = 1; ctlWrEna = ena; ctlWrContErr = ce;
    tick(); idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 count", pendCnt, 0);
    check("R1 status", stsOut, 0);
    check("R1 enables", enaOut, 0);
    check("R1 queue enable", queueEna, 0);
    check("R1 cont err", contErrOut, 0);
    check("R1 irq", irqOut, 0);
    check("R11 quiescent at reset", quiescent, 1);

    // R2 / R4 table walk
    for (int i = 0; i < NV; i++) begin
      bellWrEn = VEC[i][17]; bellWrData = VEC[i][16:9]; fetchTake = VEC[i][8];
      tick(); idle();
      check($sformatf("R2 R4 vector %0d", i), pendCnt, VEC[i][7:0]);
    end

    // R12 load while quiescent
    ctlWrite(1, 0);
    check("R12 enable loaded", queueEna, 1);
    check("R11 not quiescent when enabled", quiescent, 0);
    ctlWrite(1, 1);
    check("R12 cont err unchanged when busy", contErrOut, 0);

    // R5 / R9 mailbox and engine error do not stop queue
    mboxWr = 1; tick(); idle();
    check("R5 mailbox bit", stsOut, 5'b00001);
    engSwErr = 1; tick(); idle();
    check("R5 engine bit", stsOut, 5'b10001);
    check("R9 bits 0/4 keep queue", queueEna, 1);

    // R7 / R8
    check("R8 irq masked", irqOut, 0);
    enaSetEn = 1; enaSetData = 5'b10000; tick(); idle();
    check("R7 enable set", enaOut, 5'b10000);
    check("R8 irq raised", irqOut, 1);
    enaClrEn = 1; enaClrData = 5'b10000; tick(); idle();
    check("R7 enable cleared", enaOut, 5'b00000);
    check("R8 irq dropped", irqOut, 0);
    enaSetEn = 1; enaSetData = 5'b00001; enaClrEn = 1; enaClrData = 5'b00001; tick(); idle();
    check("R7 set wins", enaOut, 5'b00001);
    check("R8 irq mailbox", irqOut, 1);

    // R5 clear and set-wins
    stsClrEn = 1; stsClrData = 5'b10001; tick(); idle();
    check("R5 w1c", stsOut, 5'b00000);
    stsClrEn = 1; stsClrData = 5'b00001; mboxWr = 1; tick(); idle();
    check("R5 set beats clear", stsOut, 5'b00001);
    stsClrEn = 1; stsClrData = 5'b11111; tick(); idle();

    // R9 read error stops queue
    fetchRdErr = 1; tick(); idle();
    check("R5 read err bit", stsOut, 5'b00100);
    check("R9 read err stops", queueEna, 0);

    // R11 / R12 in flight
    inflightCnt = 8'd3; #1;
    check("R11 busy in flight", quiescent, 0);
    ctlWrite(1, 1);
    check("R12 ignored while in flight", queueEna, 0);
    inflightCnt = 8'd0;
    ctlWrite(1, 1);
    check("R12 quiescent load ena", queueEna, 1);
    check("R12 quiescent load cont err", contErrOut, 1);

    // R10 continue on error
    resWrErr = 1; tick(); idle();
    check("R5 write err bit", stsOut, 5'b01100);
    check("R10 write err tolerated", queueEna, 1);
    stsSetEn = 1; stsSetData = 5'b00010; tick(); idle();
    check("R6 sw set ovf bit", stsOut, 5'b01110);
    check("R10 sw ovf tolerated", queueEna, 1);

    // R12 clear while busy
    ctlWrite(0, 0);
    check("R12 clear while busy", queueEna, 0);
    check("R12 cont err kept", contErrOut, 1);
    ctlWrite(1, 0);
    stsClrEn = 1; stsClrData = 5'b11111; tick(); idle();
    stsSetEn = 1; stsSetData = 5'b01000; tick(); idle();
    check("R6 sw set write err", stsOut, 5'b01000);
    check("R9 sw set stops", queueEna, 0);

    // R3 overflow
    stsClrEn = 1; stsClrData = 5'b11111; tick(); idle();
    ctlWrite(1, 0);
    bellWrEn = 1; bellWrData = 8'd248; tick(); idle();
    check("R2 near top", pendCnt, 248);
    check("R3 no ovf yet", stsOut, 5'b00000);
    bellWrEn = 1; bellWrData = 8'd16; tick(); idle();
    check("R3 wrapped count", pendCnt, 8);
    check("R3 ovf bit", stsOut, 5'b00010);
    check("R9 ovf stops", queueEna, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule